// File: doc/BRIEF.md
# DDR3 Mode-Register Initialization Sequencer

This block sits on the controller side of a DDR3 memory channel and brings the ranks out of power-up. After a start pulse it visits the ranks in ascending index order. For each rank marked present it issues a fixed series of commands on a command bus: a NOP, a long power-up wait, writes to the mode registers MR2, MR3, MR1 and MR0, and a long ZQ calibration. It skips absent ranks without driving anything. The mode-register contents are computed from the selected CAS latency, write recovery and speed grade, and from per-rank termination codes.

DIMMs hold two ranks each, so rank r belongs to DIMM r>>1. On a DIMM whose mirror flag is set, the odd rank has some address and bank pins swapped by the board routing. The sequencer exchanges those pins on the way out, so the DRAM receives the intended value. Every command is held for a set number of clock cycles and is followed by an idle gap. All waits are counted in clock cycles set by parameters.

All pins are plain control and status signals. There is no streaming interface and no back-pressure: the command bus is driven every cycle and the receiving PHY must accept it.

Top module: `ddr3_mrs_seq`

## Requirements
- R1: After reset, cmd_o is 0 (idle), cs_o, addr_o and ba_o are 0, and busy_o and done_o are low.
- R2: A start pulse while idle makes the block visit ranks 0 to NUM_RANKS-1. For each rank with rank_present_i[r]=1 it issues, in this order: NOP, MR2, MR3, MR1, MR0, ZQCL. Absent ranks get no command. cmd_o encodes 0=idle, 1=NOP, 2=mode-register set, 3=ZQ long calibration.
- R3: Each command is held for exactly T_CMD cycles, with cs_o one-hot on the target rank, and is followed by idle cycles with cs_o=0. The idle gap lasts T_PWRUP cycles after a NOP and T_GAP cycles after a mode-register command.
- R4: MR2 is sent with ba_o=2, speed_idx_i at addr_o[5:3], the rank's 2-bit field rtt_wr_i[2r+1:2r] at addr_o[10:9], and all other bits 0.
- R5: MR3 is sent with ba_o=3 and addr_o=0.
- R6: MR1 is sent with ba_o=1 and addr_o = (rtt_nom_i[8r+7:8r] << 2) | 2.
- R7: MR0 is sent with ba_o=0 and addr_o bits 3, 8 and 12 set, (cas_lat_i-4) at addr_o[6:4], (wr_rec_i-4) at addr_o[11:9], and all other bits 0.
- R8: NOP is sent with addr_o=0 and ba_o=0. ZQCL is sent with ba_o=0 and only addr_o[10] set.
- R9: For an odd rank r whose DIMM flag dimm_mirror_i[r>>1] is 1, addr_o bits 3/4, 5/6 and 7/8 are exchanged, and ba_o bits 0/1 are exchanged, on every command to that rank. Even ranks and unflagged DIMMs are sent unchanged.
- R10: busy_o is high while a sequence runs. done_o rises when the last rank has been handled and stays high until the next accepted start. With no rank present, done_o rises and no command is sent.
- R11: A start pulse while busy_o is high is ignored, and the running sequence continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse; accepted only while idle |
| rank_present_i | input | NUM_RANKS | Population mask, one bit per rank |
| dimm_mirror_i | input | NUM_RANKS/2 | Address-mirror flag, one bit per DIMM |
| cas_lat_i | input | 4 | Selected CAS latency in cycles |
| wr_rec_i | input | 4 | Selected write recovery in cycles |
| speed_idx_i | input | 3 | Speed grade index, 0 for the slowest grade |
| rtt_wr_i | input | 2*NUM_RANKS | Per-rank dynamic write termination code |
| rtt_nom_i | input | 8*NUM_RANKS | Per-rank nominal termination code |
| cmd_o | output | 3 | Command code (0 idle, 1 NOP, 2 MRS, 3 ZQCL) |
| ba_o | output | BA_W | Bank address |
| addr_o | output | ROW_W | Row address |
| cs_o | output | NUM_RANKS | Active-high chip select, one-hot during a command |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | Sequence complete; held until next start |

## Verification
The bench builds the block with NUM_RANKS=4, T_CMD=4, T_GAP=2 and T_PWRUP=12. With waits this short, complete four-rank sequences, partial population masks, an empty mask and a mid-sequence start all fit in a short run. Every command length and every idle gap is measured against its parameter. The bench drives mirror flags on each DIMM separately, so swapped and unswapped odd ranks both appear next to untouched even ranks.

// File: rtl/ddr3_mrs_pkg.sv
package ddr3_mrs_pkg;

  typedef enum logic [2:0] {
    BUS_IDLE = 3'd0,
    BUS_NOP  = 3'd1,
    BUS_MRS  = 3'd2,
    BUS_ZQCL = 3'd3
  } bus_cmd_e;

  typedef enum logic [2:0] {
    STEP_NOP = 3'd0,
    STEP_MR2 = 3'd1,
    STEP_MR3 = 3'd2,
    STEP_MR1 = 3'd3,
    STEP_MR0 = 3'd4,
    STEP_ZQ  = 3'd5
  } step_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_SCAN = 2'd1,
    SQ_CMD  = 2'd2,
    SQ_GAP  = 2'd3
  } seq_state_e;

  // Bit that lands on position i after board mirroring of a rank.
  function automatic int addr_partner(input int i);
    case (i)
      3: return 4;
      4: return 3;
      5: return 6;
      6: return 5;
      7: return 8;
      8: return 7;
      default: return i;
    endcase
  endfunction

  function automatic int bank_partner(input int i);
    case (i)
      0: return 1;
      1: return 0;
      default: return i;
    endcase
  endfunction

  function automatic bus_cmd_e step_cmd(input step_e s);
    case (s)
      STEP_NOP: return BUS_NOP;
      STEP_ZQ:  return BUS_ZQCL;
      default:  return BUS_MRS;
    endcase
  endfunction

  function automatic step_e step_after(input step_e s);
    case (s)
      STEP_NOP: return STEP_MR2;
      STEP_MR2: return STEP_MR3;
      STEP_MR3: return STEP_MR1;
      STEP_MR1: return STEP_MR0;
      STEP_MR0: return STEP_ZQ;
      default:  return STEP_NOP;
    endcase
  endfunction

endpackage

// File: rtl/ddr3_mrs_fields.sv
module ddr3_mrs_fields
  import ddr3_mrs_pkg::*;
#(
  parameter int ROW_W = 16,
  parameter int BA_W  = 3,
  parameter int NOM_W = 8
) (
  input  step_e              step_i,
  input  logic [3:0]         cas_lat_i,
  input  logic [3:0]         wr_rec_i,
  input  logic [2:0]         speed_i,
  input  logic [1:0]         rtt_wr_i,
  input  logic [NOM_W-1:0]   rtt_nom_i,
  output logic [ROW_W-1:0]   addr_o,
  output logic [BA_W-1:0]    ba_o
);

  logic [3:0] cl_off;
  logic [3:0] wr_off;

  assign cl_off = cas_lat_i - 4'd4;
  assign wr_off = wr_rec_i - 4'd4;

  always_comb begin
    addr_o = '0;
    ba_o   = '0;
    case (step_i)
      STEP_MR2: begin
        ba_o         = BA_W'(2);
        addr_o[5:3]  = speed_i;
        addr_o[10:9] = rtt_wr_i;
      end
      STEP_MR3: begin
        ba_o = BA_W'(3);
      end
      STEP_MR1: begin
        ba_o                  = BA_W'(1);
        addr_o[NOM_W+1:2]     = rtt_nom_i;
        addr_o[1]             = 1'b1;
      end
      STEP_MR0: begin
        addr_o[3]    = 1'b1;
        addr_o[8]    = 1'b1;
        addr_o[12]   = 1'b1;
        addr_o[6:4]  = cl_off[2:0];
        addr_o[11:9] = wr_off[2:0];
      end
      STEP_ZQ: begin
        addr_o[10] = 1'b1;
      end
      default: begin
        addr_o = '0;
      end
    endcase
  end

endmodule

// File: rtl/ddr3_addr_mirror.sv
module ddr3_addr_mirror
  import ddr3_mrs_pkg::*;
#(
  parameter int ROW_W = 16,
  parameter int BA_W  = 3
) (
  input  logic             en_i,
  input  logic [ROW_W-1:0] addr_i,
  input  logic [BA_W-1:0]  ba_i,
  output logic [ROW_W-1:0] addr_o,
  output logic [BA_W-1:0]  ba_o
);

  for (genvar g = 0; g < ROW_W; g++) begin : g_addr
    localparam int P = addr_partner(g);
    assign addr_o[g] = en_i ? addr_i[P] : addr_i[g];
  end

  for (genvar g = 0; g < BA_W; g++) begin : g_bank
    localparam int P = bank_partner(g);
    assign ba_o[g] = en_i ? ba_i[P] : ba_i[g];
  end

  // R9: swapping preserves the number of set bits
  always_comb begin
    p_swap_popcount_r9: assert ($countones(addr_o) == $countones(addr_i));
  end

endmodule

// File: rtl/ddr3_mrs_fsm.sv
module ddr3_mrs_fsm
  import ddr3_mrs_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int T_CMD     = 8,
  parameter int T_GAP     = 2,
  parameter int T_PWRUP   = 40,
  localparam int RANK_W   = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start_i,
  input  logic [NUM_RANKS-1:0] present_i,
  output logic                 active_o,
  output step_e                step_o,
  output logic [RANK_W-1:0]    rank_o,
  output logic                 busy_o,
  output logic                 done_o
);

  localparam int MAX_A   = (T_CMD > T_GAP) ? T_CMD : T_GAP;
  localparam int MAX_W   = (MAX_A > T_PWRUP) ? MAX_A : T_PWRUP;
  localparam int CNT_W   = $clog2(MAX_W + 1);
  localparam logic [RANK_W-1:0] LAST_RANK = RANK_W'(NUM_RANKS - 1);
  localparam logic [CNT_W-1:0]  LD_CMD    = CNT_W'(T_CMD - 1);
  localparam logic [CNT_W-1:0]  LD_GAP    = CNT_W'(T_GAP - 1);
  localparam logic [CNT_W-1:0]  LD_PWRUP  = CNT_W'(T_PWRUP - 1);

  seq_state_e        state_q;
  step_e             step_q;
  logic [RANK_W-1:0] rank_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              done_q;
  logic              last_rank;

  assign last_rank = (rank_q == LAST_RANK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      step_q  <= STEP_NOP;
      rank_q  <= '0;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      case (state_q)
        SQ_IDLE: begin
          if (start_i) begin
            done_q  <= 1'b0;
            rank_q  <= '0;
            state_q <= SQ_SCAN;
          end
        end
        SQ_SCAN: begin
          if (present_i[rank_q]) begin
            step_q  <= STEP_NOP;
            cnt_q   <= LD_CMD;
            state_q <= SQ_CMD;
          end else if (last_rank) begin
            done_q  <= 1'b1;
            state_q <= SQ_IDLE;
          end else begin
            rank_q <= rank_q + 1'b1;
          end
        end
        SQ_CMD: begin
          if (cnt_q == '0) begin
            cnt_q   <= (step_q == STEP_NOP) ? LD_PWRUP : LD_GAP;
            state_q <= SQ_GAP;
          end else begin
            cnt_q <= cnt_q - 1'b1;
          end
        end
        SQ_GAP: begin
          if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
          end else if (step_q != STEP_ZQ) begin
            step_q  <= step_after(step_q);
            cnt_q   <= LD_CMD;
            state_q <= SQ_CMD;
          end else if (last_rank) begin
            done_q  <= 1'b1;
            state_q <= SQ_IDLE;
          end else begin
            rank_q  <= rank_q + 1'b1;
            state_q <= SQ_SCAN;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign active_o = (state_q == SQ_CMD);
  assign step_o   = step_q;
  assign rank_o   = rank_q;
  assign busy_o   = (state_q != SQ_IDLE);
  assign done_o   = done_q;

  // R3: a command keeps its step and rank for its whole hold window
  p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == SQ_CMD && cnt_q != '0) |=>
      (state_q == SQ_CMD && $stable(step_q) && $stable(rank_q)));

  // R10: done stays up until a start is seen
  p_done_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (done_q && !start_i) |=> done_q);

  // R11: a start during a sequence never restarts the rank walk
  p_start_ignored_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && start_i && rank_q != '0) |=> (rank_q != '0));

endmodule

// File: rtl/ddr3_mrs_seq.sv
module ddr3_mrs_seq
  import ddr3_mrs_pkg::*;
#(
  parameter int NUM_RANKS = 4,
  parameter int ROW_W     = 16,
  parameter int BA_W      = 3,
  parameter int T_CMD     = 8,
  parameter int T_GAP     = 2,
  parameter int T_PWRUP   = 40,
  localparam int NUM_DIMMS = NUM_RANKS / 2,
  localparam int NOM_W     = 8,
  localparam int RANK_W    = (NUM_RANKS > 1) ? $clog2(NUM_RANKS) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic [NUM_RANKS-1:0]       rank_present_i,
  input  logic [NUM_DIMMS-1:0]       dimm_mirror_i,
  input  logic [3:0]                 cas_lat_i,
  input  logic [3:0]                 wr_rec_i,
  input  logic [2:0]                 speed_idx_i,
  input  logic [2*NUM_RANKS-1:0]     rtt_wr_i,
  input  logic [NOM_W*NUM_RANKS-1:0] rtt_nom_i,
  output logic [2:0]                 cmd_o,
  output logic [BA_W-1:0]            ba_o,
  output logic [ROW_W-1:0]           addr_o,
  output logic [NUM_RANKS-1:0]       cs_o,
  output logic                       busy_o,
  output logic                       done_o
);

  logic              active;
  step_e             step;
  logic [RANK_W-1:0] rank;
  logic [ROW_W-1:0]  raw_addr;
  logic [BA_W-1:0]   raw_ba;
  logic [ROW_W-1:0]  sw_addr;
  logic [BA_W-1:0]   sw_ba;
  logic              swap_en;
  logic [1:0]        rank_wr;
  logic [NOM_W-1:0]  rank_nom;

  ddr3_mrs_fsm #(
    .NUM_RANKS (NUM_RANKS),
    .T_CMD     (T_CMD),
    .T_GAP     (T_GAP),
    .T_PWRUP   (T_PWRUP)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .present_i (rank_present_i),
    .active_o  (active),
    .step_o    (step),
    .rank_o    (rank),
    .busy_o    (busy_o),
    .done_o    (done_o)
  );

  assign rank_wr  = rtt_wr_i[rank*2 +: 2];
  assign rank_nom = rtt_nom_i[rank*NOM_W +: NOM_W];

  ddr3_mrs_fields #(
    .ROW_W (ROW_W),
    .BA_W  (BA_W),
    .NOM_W (NOM_W)
  ) u_fields (
    .step_i    (step),
    .cas_lat_i (cas_lat_i),
    .wr_rec_i  (wr_rec_i),
    .speed_i   (speed_idx_i),
    .rtt_wr_i  (rank_wr),
    .rtt_nom_i (rank_nom),
    .addr_o    (raw_addr),
    .ba_o      (raw_ba)
  );

  assign swap_en = rank[0] && dimm_mirror_i[rank >> 1];

  ddr3_addr_mirror #(
    .ROW_W (ROW_W),
    .BA_W  (BA_W)
  ) u_mirror (
    .en_i   (swap_en),
    .addr_i (raw_addr),
    .ba_i   (raw_ba),
    .addr_o (sw_addr),
    .ba_o   (sw_ba)
  );

  always_comb begin
    cmd_o  = BUS_IDLE;
    cs_o   = '0;
    addr_o = '0;
    ba_o   = '0;
    if (active) begin
      cmd_o       = step_cmd(step);
      cs_o[rank]  = 1'b1;
      addr_o      = sw_addr;
      ba_o        = sw_ba;
    end
  end

  // R3: at most one rank selected
  p_cs_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs_o));

  // R3: chip select and command code agree on bus activity
  p_cs_matches_cmd_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cs_o != '0) == (cmd_o != 3'd0)));

  // R9: even ranks leave the field logic untouched
  p_even_passthru_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !rank[0]) |-> (addr_o == raw_addr && ba_o == raw_ba));

  // R1: no command while no sequence runs
  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> (cmd_o == 3'd0));

endmodule

// File: tb/ddr3_mrs_seq_tb.sv
module ddr3_mrs_seq_tb;

  localparam int NR      = 4;
  localparam int ROW_W   = 16;
  localparam int BA_W    = 3;
  localparam int T_CMD   = 4;
  localparam int T_GAP   = 2;
  localparam int T_PWRUP = 12;

  typedef struct packed {
    logic [2:0]       cmd;
    logic [NR-1:0]    cs;
    logic [BA_W-1:0]  ba;
    logic [ROW_W-1:0] addr;
  } item_t;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [NR-1:0]     present = '0;
  logic [NR/2-1:0]   mirror = '0;
  logic [3:0]        cl = 4'd6;
  logic [3:0]        wr = 4'd6;
  logic [2:0]        spd = 3'd0;
  logic [2*NR-1:0]   rwr = '0;
  logic [8*NR-1:0]   rnom = '0;
  logic [2:0]        cmd;
  logic [BA_W-1:0]   ba;
  logic [ROW_W-1:0]  addr;
  logic [NR-1:0]     cs;
  logic              busy;
  logic              done;

  int checks = 0;
  int errors = 0;
  string cur_req = "R2";
  item_t exp_q[$];

  always #5 clk = ~clk;

  ddr3_mrs_seq #(
    .NUM_RANKS (NR), .ROW_W (ROW_W), .BA_W (BA_W),
    .T_CMD (T_CMD), .T_GAP (T_GAP), .T_PWRUP (T_PWRUP)
  ) u_dut (
    .clk (clk), .rst_n (rst_n), .start_i (start),
    .rank_present_i (present), .dimm_mirror_i (mirror),
    .cas_lat_i (cl), .wr_rec_i (wr), .speed_idx_i (spd),
    .rtt_wr_i (rwr), .rtt_nom_i (rnom),
    .cmd_o (cmd), .ba_o (ba), .addr_o (addr), .cs_o (cs),
    .busy_o (busy), .done_o (done)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic item_t mk(input logic [2:0] c, input int r,
                               input logic [BA_W-1:0] b, input logic [ROW_W-1:0] a);
    item_t it;
    logic [ROW_W-1:0] aa;
    logic [BA_W-1:0] bb;
    aa = a;
    bb = b;
    if ((r % 2) == 1 && mirror[r/2]) begin
      aa[3] = a[4]; aa[4] = a[3];
      aa[5] = a[6]; aa[6] = a[5];
      aa[7] = a[8]; aa[8] = a[7];
      bb[0] = b[1]; bb[1] = b[0];
    end
    it.cmd = c;
    it.cs = '0;
    it.cs[r] = 1'b1;
    it.ba = bb;
    it.addr = aa;
    return it;
  endfunction

  task automatic push_expected();
    for (int r = 0; r < NR; r++) begin
      if (present[r]) begin
        logic [ROW_W-1:0] a;
        logic [3:0] clm, wrm;
        exp_q.push_back(mk(3'd1, r, '0, '0));                     // R8 NOP
        a = '0; a[5:3] = spd; a[10:9] = rwr[2*r +: 2];
        exp_q.push_back(mk(3'd2, r, 3'd2, a));                    // R4
        exp_q.push_back(mk(3'd2, r, 3'd3, '0));                   // R5
        a = '0; a[9:2] = rnom[8*r +: 8]; a[1] = 1'b1;
        exp_q.push_back(mk(3'd2, r, 3'd1, a));                    // R6
        clm = cl - 4'd4; wrm = wr - 4'd4;
        a = '0; a[3] = 1'b1; a[8] = 1'b1; a[12] = 1'b1;
        a[6:4] = clm[2:0]; a[11:9] = wrm[2:0];
        exp_q.push_back(mk(3'd2, r, 3'd0, a));                    // R7
        a = '0; a[10] = 1'b1;
        exp_q.push_back(mk(3'd3, r, '0, a));                      // R8 ZQCL
      end
    end
  endtask

  task automatic launch();
    @(negedge clk);
    push_expected();
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 5000) begin
      @(negedge clk);
      n++;
    end
    check(done === 1'b1, req, "done after sequence", done, 1);
    check(exp_q.size() == 0, req, "expected commands left", exp_q.size(), 0);
    repeat (3) @(negedge clk);
    check(done === 1'b1, "R10", "done held", done, 1);
    check(busy === 1'b0, "R10", "busy after done", busy, 0);
    check(cmd === 3'd0, "R10", "bus idle after done", cmd, 0);
  endtask

  // Monitor: pops expected commands and measures hold and gap lengths
  logic [2:0] prev_cmd = 3'd0;
  logic [2:0] last_kind = 3'd0;
  int hold = 0;
  int gap = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (cmd != 3'd0 && prev_cmd == 3'd0) begin
        if (last_kind == 3'd1)
          check(gap == T_PWRUP, "R3", "gap after NOP", gap, T_PWRUP);
        else if (last_kind == 3'd2)
          check(gap == T_GAP, "R3", "gap after MRS", gap, T_GAP);
        if (exp_q.size() == 0) begin
          check(1'b0, cur_req, "unexpected command", {cmd, cs, ba, addr}, 0);
        end else begin
          item_t e;
          item_t got;
          e = exp_q.pop_front();
          got = '{cmd: cmd, cs: cs, ba: ba, addr: addr};
          check(got == e, cur_req, "command {cmd,cs,ba,addr}", got, e);
        end
        hold = 1;
        last_kind = cmd;
      end else if (cmd != 3'd0) begin
        hold++;
      end else if (prev_cmd != 3'd0) begin
        check(hold == T_CMD, "R3", "command hold length", hold, T_CMD);
        gap = 1;
      end else begin
        gap++;
      end
      if (!busy) last_kind = 3'd0;
      prev_cmd = cmd;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cmd === 3'd0 && cs === '0 && addr === '0 && ba === '0, "R1",
          "bus in reset", {cmd, cs, ba, addr}, 0);
    check(busy === 1'b0 && done === 1'b0, "R1", "busy/done in reset", {busy, done}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cmd === 3'd0 && busy === 1'b0 && done === 1'b0, "R1",
          "idle after reset", {cmd, busy, done}, 0);

    // All ranks, no mirroring
    cur_req = "R2/R4/R5/R6/R7/R8";
    present = 4'b1111; mirror = 2'b00; cl = 4'd7; wr = 4'd8; spd = 3'd2;
    rwr = 8'b10_00_10_01; rnom = 32'h11_81_00_81;
    launch();
    check(busy === 1'b1, "R10", "busy during sequence", busy, 1);
    check(done === 1'b0, "R10", "done cleared by start", done, 0);
    wait_done("R2");

    // Sparse population: ranks 1 and 3 absent
    cur_req = "R2 skip";
    present = 4'b0101; cl = 4'd11; wr = 4'd12; spd = 3'd5;
    rwr = 8'b11_01_10_11; rnom = 32'h3f_22_81_11;
    launch();
    wait_done("R2");

    // Mirrored second DIMM: rank 3 swapped, rank 1 not
    cur_req = "R9";
    present = 4'b1111; mirror = 2'b10; cl = 4'd5; wr = 4'd6; spd = 3'd1;
    rwr = 8'b10_10_01_10; rnom = 32'h81_11_81_55;
    launch();
    wait_done("R9");

    // Mirrored first DIMM, both DIMMs mirrored odd ranks differ
    cur_req = "R9";
    mirror = 2'b11; spd = 3'd6; cl = 4'd9; wr = 4'd10;
    launch();
    wait_done("R9");

    // Empty mask: done with no command
    cur_req = "R10";
    present = 4'b0000;
    launch();
    wait_done("R10");

    // Start pulses mid-sequence are ignored
    cur_req = "R11";
    present = 4'b1010; mirror = 2'b01; spd = 3'd3;
    launch();
    repeat (40) @(negedge clk);
    check(busy === 1'b1, "R11", "still busy before extra start", busy, 1);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (30) @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done("R11");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule